// File: doc/BRIEF.md
# Repeater False-Carrier Disconnect Monitor

This block sits beside the receive PCS of a 100 Mb/s PHY running in repeater mode. It decides whether received data may still reach the MII. A false carrier is a carrier event whose J-K start delimiter did not decode correctly. The PCS reports each false carrier and each good frame as a single-cycle pulse. It also gives a carrier level, an idle level and a bit-time tick. The monitor cuts the port off when false carriers arrive back to back, or when one false carrier runs too long. It restores the port after a long enough clean carrier or a long enough idle stretch.

The monitor also keeps a saturating 8-bit count of false carriers and a sticky flag that records any disconnect. Management software reads both through a single read strobe, and the read clears them. An event that lands in the same cycle as the read is kept, so no event is lost. The gate output is high while receive data may pass.

Top module: `rptr_fc_guard`

## Requirements
- R1: After reset, `rx_pass_o` is 1, `rd_fc_cnt_o` is 0 and `rd_disc_o` is 0.
- R2: With repeater mode and disconnect enable both 1, a second false-carrier pulse with no good-frame pulse since the first drives `rx_pass_o` to 0 in the next cycle.
- R3: A good-frame pulse between two false-carrier pulses prevents that disconnect. A later false carrier then pairs with the second one.
- R4: A false carrier whose carrier level stays high for LONG_BT (default 484) bit-time ticks disconnects on its last tick. LONG_BT-1 ticks do not.
- R5: While disconnected, a carrier with no false-carrier pulse that lasts GOOD_BT (default 480) ticks reconnects (`rx_pass_o` back to 1). GOOD_BT-1 ticks do not.
- R6: While disconnected, the idle level held for IDLE_BT (default 25000) ticks reconnects. IDLE_BT-1 ticks do not.
- R7: If repeater mode is 0, the disconnect-enable bit has no effect and no disconnect occurs. If the enable is 0, no disconnect occurs either. Clearing either bit while disconnected restores `rx_pass_o` in the next cycle.
- R8: Every false-carrier pulse increments `rd_fc_cnt_o` by one, whatever the mode bits are. The count saturates at 255 and does not wrap.
- R9: In a cycle with `rd_i` high, `rd_fc_cnt_o` and `rd_disc_o` show the values held so far. Both are 0 in the following cycle.
- R10: If a false carrier or a disconnect coincides with `rd_i`, the cleared count becomes 1 and the flag becomes 1.
- R11: `rd_disc_o` goes to 1 in the same cycle that `rx_pass_o` falls. It stays 1 through a later reconnect until it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rptr_mode_i | input | 1 | Repeater mode selected |
| disc_en_i | input | 1 | Disconnect function enabled |
| bt_tick_i | input | 1 | One pulse per bit time |
| carrier_i | input | 1 | Carrier event in progress |
| fc_i | input | 1 | Pulse: current carrier is a false carrier |
| good_frame_i | input | 1 | Pulse: a good frame was received |
| idle_i | input | 1 | Idle symbols being received |
| rd_i | input | 1 | Management read strobe, clears the statistics |
| rd_fc_cnt_o | output | 8 | False-carrier count |
| rd_disc_o | output | 1 | A disconnect occurred since the last read |
| rx_pass_o | output | 1 | 1 = receive data may reach the MII |

## Verification
A wrong pairing flag shows up at the very next false carrier: `rx_pass_o` falls when it should not, or stays high when it should fall, one cycle after the pulse. A bit-time window that is off by one is caught by runs of exactly the threshold length and one tick less. The gate reveals the error one cycle after the final tick. Errors in the count or the flag, such as a missed clear, a wrap or a lost coincident event, are visible at the next read strobe.

// File: rtl/rptr_fc_guard_pkg.sv
package rptr_fc_guard_pkg;
  localparam int unsigned DEF_LONG_BT = 484;
  localparam int unsigned DEF_GOOD_BT = 480;
  localparam int unsigned DEF_IDLE_BT = 25000;
  localparam int unsigned DEF_CNT_W   = 8;

  typedef enum logic [1:0] {
    WIN_LONG = 2'd0,
    WIN_GOOD = 2'd1,
    WIN_IDLE = 2'd2
  } win_e;
endpackage

// File: rtl/rfg_bt_window.sv
module rfg_bt_window #(
  parameter int unsigned LIMIT = 480
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] count_q;

  // pulse on the tick that completes LIMIT bit times
  assign hit_o = run_i && tick_i && (count_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    count_q <= '0;
    else if (!run_i)                                count_q <= '0;
    else if (tick_i && (count_q != CW'(LIMIT)))     count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/rfg_link_guard.sv
module rfg_link_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic carrier_i,
  input  logic fc_i,
  input  logic good_frame_i,
  input  logic long_hit_i,
  input  logic good_hit_i,
  input  logic idle_hit_i,
  output logic pass_o,
  output logic disc_evt_o
);
  logic disc_q, armed_q, fc_act_q;
  logic fc_now, disc_set, recon;

  assign fc_now     = fc_i | fc_act_q;
  assign disc_set   = active_i & ~disc_q & ((fc_i & armed_q) | (long_hit_i & fc_now));
  assign recon      = disc_q & ((good_hit_i & ~fc_now) | idle_hit_i);
  assign disc_evt_o = disc_set;
  assign pass_o     = ~disc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         fc_act_q <= 1'b0;
    else if (!carrier_i) fc_act_q <= 1'b0;
    else if (fc_i)       fc_act_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disc_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (!active_i) begin
      disc_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (disc_set) begin
      disc_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (recon) begin
      disc_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (!disc_q) begin
      if (fc_i)              armed_q <= 1'b1;
      else if (good_frame_i) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rfg_stats.sv
module rfg_stats #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fc_i,
  input  logic             disc_evt_i,
  input  logic             rd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q, cnt_base, cnt_d;
  logic             flag_q;

  // clear-on-read first, then record the coincident event
  assign cnt_base = rd_i ? '0 : cnt_q;
  assign cnt_d    = (fc_i && cnt_base != CNT_MAX) ? cnt_base + 1'b1 : cnt_base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= (flag_q & ~rd_i) | disc_evt_i;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/rptr_fc_guard.sv
module rptr_fc_guard
  import rptr_fc_guard_pkg::*;
#(
  parameter int unsigned LONG_BT = DEF_LONG_BT,
  parameter int unsigned GOOD_BT = DEF_GOOD_BT,
  parameter int unsigned IDLE_BT = DEF_IDLE_BT,
  parameter int unsigned CNT_W   = DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rptr_mode_i,
  input  logic             disc_en_i,
  input  logic             bt_tick_i,
  input  logic             carrier_i,
  input  logic             fc_i,
  input  logic             good_frame_i,
  input  logic             idle_i,
  input  logic             rd_i,
  output logic [CNT_W-1:0] rd_fc_cnt_o,
  output logic             rd_disc_o,
  output logic             rx_pass_o
);
  localparam int unsigned NWIN = 3;
  logic [NWIN-1:0] hit;
  logic            active, disc_evt;

  assign active = rptr_mode_i & disc_en_i;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam int unsigned LIM = (g == int'(WIN_LONG)) ? LONG_BT :
                                  (g == int'(WIN_GOOD)) ? GOOD_BT : IDLE_BT;
    logic run;
    assign run = (g == int'(WIN_IDLE)) ? idle_i : carrier_i;
    rfg_bt_window #(.LIMIT(LIM)) u_win (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run),
      .tick_i (bt_tick_i),
      .hit_o  (hit[g])
    );
  end

  rfg_link_guard u_guard (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .active_i     (active),
    .carrier_i    (carrier_i),
    .fc_i         (fc_i),
    .good_frame_i (good_frame_i),
    .long_hit_i   (hit[WIN_LONG]),
    .good_hit_i   (hit[WIN_GOOD]),
    .idle_hit_i   (hit[WIN_IDLE]),
    .pass_o       (rx_pass_o),
    .disc_evt_o   (disc_evt)
  );

  rfg_stats #(.CNT_W(CNT_W)) u_stats (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fc_i       (fc_i),
    .disc_evt_i (disc_evt),
    .rd_i       (rd_i),
    .cnt_o      (rd_fc_cnt_o),
    .flag_o     (rd_disc_o)
  );
endmodule

// File: rtl/rptr_fc_guard_chk.sv
module rptr_fc_guard_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rptr_mode_i,
  input logic             disc_en_i,
  input logic             fc_i,
  input logic             rd_i,
  input logic [CNT_W-1:0] rd_fc_cnt_o,
  input logic             rd_disc_o,
  input logic             rx_pass_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  p_inactive_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rptr_mode_i || !disc_en_i) |=> rx_pass_o);

  p_cnt_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && fc_i && rd_fc_cnt_o != CMAX) |=> rd_fc_cnt_o == $past(rd_fc_cnt_o) + 1'b1);

  p_no_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && rd_fc_cnt_o == CMAX) |=> rd_fc_cnt_o == CMAX);

  p_rd_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !fc_i) |=> rd_fc_cnt_o == '0);

  p_rd_keep_evt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && fc_i) |=> rd_fc_cnt_o == CNT_W'(1));

  p_flag_on_cut_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_pass_o) |-> rd_disc_o);

  p_flag_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_disc_o && !rd_i) |=> rd_disc_o);
endmodule

bind rptr_fc_guard rptr_fc_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rptr_mode_i (rptr_mode_i),
  .disc_en_i   (disc_en_i),
  .fc_i        (fc_i),
  .rd_i        (rd_i),
  .rd_fc_cnt_o (rd_fc_cnt_o),
  .rd_disc_o   (rd_disc_o),
  .rx_pass_o   (rx_pass_o)
);

// File: tb/rptr_fc_guard_bench.sv
module rptr_fc_guard_bench;
  localparam int LONG_BT = 484;
  localparam int GOOD_BT = 480;
  localparam int IDLE_BT = 25000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rptr_mode_i = 1'b0, disc_en_i = 1'b0, bt_tick_i = 1'b1;
  logic carrier_i = 1'b0, fc_i = 1'b0, good_frame_i = 1'b0, idle_i = 1'b0, rd_i = 1'b0;
  logic [7:0] rd_fc_cnt_o;
  logic rd_disc_o, rx_pass_o;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  rptr_fc_guard u_rptr_fc_guard (
    .clk_i(clk), .rst_ni(rst_ni), .rptr_mode_i(rptr_mode_i), .disc_en_i(disc_en_i),
    .bt_tick_i(bt_tick_i), .carrier_i(carrier_i), .fc_i(fc_i), .good_frame_i(good_frame_i),
    .idle_i(idle_i), .rd_i(rd_i), .rd_fc_cnt_o(rd_fc_cnt_o), .rd_disc_o(rd_disc_o),
    .rx_pass_o(rx_pass_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(bit rp, bit en);
    rst_ni = 1'b0; carrier_i = 0; fc_i = 0; good_frame_i = 0; idle_i = 0; rd_i = 0;
    rptr_mode_i = rp; disc_en_i = en;
    step(2);
    rst_ni = 1'b1;
    step();
  endtask

  // carrier high for n ticks, optional false-carrier pulse in the first one
  task automatic carrier(int n, bit fc);
    carrier_i = 1; fc_i = fc;
    step();
    fc_i = 0;
    step(n - 1);
    carrier_i = 0;
    step();
  endtask

  task automatic good_pulse();
    good_frame_i = 1; step(); good_frame_i = 0;
  endtask

  task automatic do_read(output int cnt, output int flag);
    rd_i = 1;
    cnt = rd_fc_cnt_o; flag = rd_disc_o;
    step();
    rd_i = 0;
  endtask

  task automatic t_reset();
    do_reset(1, 1);
    check("R1 pass", rx_pass_o, 1);
    check("R1 cnt", rd_fc_cnt_o, 0);
    check("R1 flag", rd_disc_o, 0);
  endtask

  task automatic t_pair();
    do_reset(1, 1);
    carrier(3, 1);
    check("R2 pass after first fc", rx_pass_o, 1);
    carrier_i = 1; fc_i = 1; step(); fc_i = 0;
    check("R2 pass after second fc", rx_pass_o, 0);
    carrier_i = 0; step();
  endtask

  task automatic t_good_between();
    do_reset(1, 1);
    carrier(3, 1);
    good_pulse();
    carrier(3, 1);
    check("R3 good frame breaks pair", rx_pass_o, 1);
    carrier(3, 1);
    check("R3 later pair still cuts", rx_pass_o, 0);
  endtask

  task automatic t_long();
    do_reset(1, 1);
    carrier(LONG_BT - 1, 1);
    check("R4 LONG_BT-1 ticks", rx_pass_o, 1);
    good_pulse();
    carrier(LONG_BT, 1);
    check("R4 LONG_BT ticks", rx_pass_o, 0);
  endtask

  task automatic t_good_reconnect();
    int c, f;
    do_reset(1, 1);
    carrier(3, 1); carrier(3, 1);
    check("R5 disconnected", rx_pass_o, 0);
    carrier(GOOD_BT - 1, 0);
    check("R5 GOOD_BT-1 ticks", rx_pass_o, 0);
    carrier(GOOD_BT, 0);
    check("R5 GOOD_BT ticks", rx_pass_o, 1);
    do_read(c, f);
    check("R11 flag survives reconnect", f, 1);
    check("R8 count two", c, 2);
  endtask

  task automatic t_idle();
    do_reset(1, 1);
    carrier(3, 1); carrier(3, 1);
    idle_i = 1; step(IDLE_BT - 1); idle_i = 0; step();
    check("R6 IDLE_BT-1 ticks", rx_pass_o, 0);
    idle_i = 1; step(IDLE_BT - 1);
    check("R6 before last tick", rx_pass_o, 0);
    step();
    check("R6 IDLE_BT ticks", rx_pass_o, 1);
    idle_i = 0; step();
  endtask

  task automatic t_inactive();
    int c, f;
    do_reset(0, 1);
    carrier(3, 1); carrier(3, 1);
    check("R7 repeater off", rx_pass_o, 1);
    do_read(c, f);
    check("R8 counts with repeater off", c, 2);
    check("R7 no flag", f, 0);
    do_reset(1, 0);
    carrier(3, 1); carrier(3, 1);
    check("R7 enable off", rx_pass_o, 1);
    do_reset(1, 1);
    carrier(3, 1); carrier(3, 1);
    check("R7 cut before clear", rx_pass_o, 0);
    disc_en_i = 0; step();
    check("R7 clearing enable restores", rx_pass_o, 1);
  endtask

  task automatic t_sat();
    int c, f;
    do_reset(0, 0);
    for (int i = 0; i < 300; i++) begin
      fc_i = 1; step(); fc_i = 0; step();
    end
    check("R8 saturate at 255", rd_fc_cnt_o, 255);
    do_read(c, f);
    check("R9 read shows held count", c, 255);
    check("R9 cleared after read", rd_fc_cnt_o, 0);
  endtask

  task automatic t_read();
    int c, f;
    do_reset(1, 1);
    carrier(3, 1); carrier(3, 1); carrier(3, 1);
    do_read(c, f);
    check("R9 read count", c, 3);
    check("R9 read flag", f, 1);
    check("R9 count cleared", rd_fc_cnt_o, 0);
    check("R9 flag cleared", rd_disc_o, 0);
  endtask

  task automatic t_rd_evt();
    do_reset(1, 1);
    carrier(3, 1);
    carrier_i = 1; fc_i = 1; rd_i = 1;
    check("R9 value in read cycle", rd_fc_cnt_o, 1);
    step();
    fc_i = 0; rd_i = 0;
    check("R10 coincident fc kept", rd_fc_cnt_o, 1);
    check("R10 coincident cut kept", rd_disc_o, 1);
    check("R11 flag with cut", rx_pass_o, 0);
    carrier_i = 0; step();
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_pair();
    t_good_between();
    t_long();
    t_good_reconnect();
    t_idle();
    t_inactive();
    t_sat();
    t_read();
    t_rd_evt();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule